// File: doc/BRIEF.md
# Legacy Paravirtual Device Control Register Block

This block is the slave-side register file of a legacy paravirtual device's I/O window. A host driver reaches it over a simple I/O bus. Each access carries a byte offset, a size code and, for writes, 32 bits of data. Through that window the driver reads the capability word the device offers. It also writes back the feature set it accepts, picks one of several queues and programs that queue's page frame and interrupt vector. It sets the device status byte, rings queue doorbells, and acknowledges interrupts by reading an interrupt status byte that clears itself on the read.

The common header is 20 bytes long. When the message-signalled interrupt mode input is high, it grows to 24 bytes, and two vector registers appear at offsets 20 and 22. Any offset at or past the end of the header goes to a device-specific configuration port, with the header length subtracted from the offset. A device reset can come from two writes: a zero written to the status byte, or a zero written to the page-frame register. Either one clears the negotiated state in one clock. The device side raises interrupt causes on a two-bit input. It receives each doorbell as a one-cycle strobe that carries the queue index.

Top module: `vpci_regs`

## Requirements
- R1: After the reset input, reads return 0 for guest features, status, interrupt status and queue select, 0 for every queue page frame, and 0xFFFF for every vector. The interrupt line is low.
- R2: A read at offset 0 returns the host feature input with bits 24, 28 and 30 forced to one.
- R3: A write at offset 4 stores the value, and a read at offset 4 returns it. If bit 30 of the written value is set, the stored value becomes zero instead.
- R4: A non-zero write at offset 8 stores the page frame of the selected queue. The stored form is the frame shifted left by 12. A read at offset 8 returns the stored address shifted right by 12. The other queues keep their values.
- R5: A zero written at offset 8 stores nothing and causes a device reset. A device reset clears guest features, status, interrupt status and queue select. dev_reset_o is high for the one cycle after the write.
- R6: A write at offset 18 keeps the low 8 bits of the data as the status byte, and a read at offset 18 returns it. A write whose low 8 bits are zero causes a device reset.
- R7: A write at offset 14 changes the queue select only when its low 16 bits are below NQ; otherwise the old value stays. A read at offset 12 returns sel_qsize_i, and qsel_o shows the current select.
- R8: A write at offset 16 makes notify_o high for exactly the next cycle, with notify_idx_o equal to the low 16 bits written.
- R9: A read at offset 19 returns the interrupt status and clears it at the end of the access. Bits set through isr_set_i in the same cycle survive the clear, and are ORed in at any time.
- R10: irq_o equals bit 0 of the interrupt status while msix_en is low, and is low while msix_en is high.
- R11: While msix_en is high, offset 20 holds the configuration vector and offset 22 holds the selected queue's vector. A written value above MAX_VEC is stored as 0xFFFF.
- R12: An access at or past the header end (24 with msix_en high, 20 otherwise) is forwarded on the cfg_* port with the offset minus the header length. Its read data comes from cfg_rdata_i.
- R13: A read at a header offset that starts no register (including offset 16) returns 0xFFFFFFFF. A write there changes no register.
- R14: A device reset sets every queue page frame to 0 and every vector, including the configuration vector, to 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msix_en | input | 1 | Message-signalled interrupt mode; lengthens the header to 24 bytes |
| bus_req | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size code, forwarded to the config port |
| bus_addr | input | AW | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| host_feat_i | input | 32 | Device-offered feature bits |
| sel_qsize_i | input | 16 | Size of the queue shown on qsel_o |
| qsel_o | output | 16 | Current queue select |
| isr_set_i | input | 2 | Interrupt cause set bits (bit 0 queue, bit 1 config) |
| irq_o | output | 1 | Legacy level interrupt |
| notify_o | output | 1 | Doorbell strobe |
| notify_idx_o | output | 16 | Queue index of the doorbell |
| dev_reset_o | output | 1 | One-cycle device reset pulse |
| cfg_req_o | output | 1 | Config-port access valid |
| cfg_we_o | output | 1 | Config-port write |
| cfg_size_o | output | 2 | Config-port size code |
| cfg_addr_o | output | AW | Offset into device-specific space |
| cfg_wdata_o | output | 32 | Config-port write data |
| cfg_rdata_i | input | 32 | Config-port read data |

## Verification
The hardest case to reach is an interrupt cause that arrives in the same cycle as the read that acknowledges the interrupt status. The read must return the old value while the new cause survives the clear. The random stimulus drives isr_set_i in a quarter of all accesses, so cause pulses often land on status reads. A directed case also forces this collision. Device resets come from random zero writes to the status and page-frame offsets, and the mode input toggles between accesses. This leaves vectors and page frames of several queues in mixed states before each reset, and it moves the header boundary under random offsets.

// File: rtl/vpci_pkg.sv
package vpci_pkg;

  typedef enum logic [3:0] {
    REG_NONE, REG_HFEAT, REG_GFEAT, REG_PFN, REG_QNUM, REG_QSEL,
    REG_NOTIFY, REG_STATUS, REG_ISR, REG_CVEC, REG_QVEC
  } reg_e;

  localparam int HDR_PLAIN   = 20;
  localparam int HDR_MSG     = 24;
  localparam int PAGE_SHIFT  = 12;
  localparam int BASE_W      = 32 + PAGE_SHIFT;
  localparam int CAP_EMPTY   = 24;
  localparam int CAP_INDIR   = 28;
  localparam int CAP_BADNEG  = 30;
  localparam logic [15:0] NO_VECTOR = 16'hFFFF;

  function automatic logic [31:0] host_view(input logic [31:0] f);
    logic [31:0] v;
    v = f;
    v[CAP_EMPTY]  = 1'b1;
    v[CAP_INDIR]  = 1'b1;
    v[CAP_BADNEG] = 1'b1;
    return v;
  endfunction

  function automatic logic [31:0] guest_accept(input logic [31:0] v);
    return v[CAP_BADNEG] ? 32'h0 : v;
  endfunction

  function automatic logic [15:0] vec_clamp(input logic [15:0] v, input int maxv);
    return (int'(v) > maxv) ? NO_VECTOR : v;
  endfunction

  function automatic logic [BASE_W-1:0] pfn_to_base(input logic [31:0] p);
    return {p, {PAGE_SHIFT{1'b0}}};
  endfunction

  function automatic logic [31:0] base_to_pfn(input logic [BASE_W-1:0] b);
    return b[BASE_W-1:PAGE_SHIFT];
  endfunction

endpackage

// File: rtl/vpci_decode.sv
module vpci_decode import vpci_pkg::*; #(
  parameter int AW = 8
) (
  input  logic [AW-1:0] addr,
  input  logic          msix_en,
  output reg_e          reg_id,
  output logic          in_dev,
  output logic [AW-1:0] dev_off
);
  logic [AW-1:0] hdr_len;

  assign hdr_len = msix_en ? AW'(HDR_MSG) : AW'(HDR_PLAIN);
  assign in_dev  = (addr >= hdr_len);
  assign dev_off = addr - hdr_len;

  always_comb begin
    reg_id = REG_NONE;
    case (int'(addr))
      0:  reg_id = REG_HFEAT;
      4:  reg_id = REG_GFEAT;
      8:  reg_id = REG_PFN;
      12: reg_id = REG_QNUM;
      14: reg_id = REG_QSEL;
      16: reg_id = REG_NOTIFY;
      18: reg_id = REG_STATUS;
      19: reg_id = REG_ISR;
      20: reg_id = msix_en ? REG_CVEC : REG_NONE;
      22: reg_id = msix_en ? REG_QVEC : REG_NONE;
      default: reg_id = REG_NONE;
    endcase
  end
endmodule

// File: rtl/vpci_qtable.sv
module vpci_qtable import vpci_pkg::*; #(
  parameter int NQ = 8,
  localparam int QW = $clog2(NQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [QW-1:0]     sel,
  input  logic              base_we,
  input  logic [BASE_W-1:0] base_wd,
  input  logic              vec_we,
  input  logic [15:0]       vec_wd,
  output logic [BASE_W-1:0] base_rd,
  output logic [15:0]       vec_rd
);
  logic [BASE_W-1:0] base_q [NQ];
  logic [15:0]       vec_q  [NQ];

  for (genvar q = 0; q < NQ; q++) begin : g_queue
    logic hit;
    assign hit = (int'(sel) == q);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[q] <= '0;
        vec_q[q]  <= NO_VECTOR;
      end else if (clr) begin
        base_q[q] <= '0;
        vec_q[q]  <= NO_VECTOR;
      end else begin
        if (base_we && hit) base_q[q] <= base_wd;
        if (vec_we && hit)  vec_q[q]  <= vec_wd;
      end
    end
  end

  assign base_rd = base_q[sel];
  assign vec_rd  = vec_q[sel];
endmodule

// File: rtl/vpci_regs.sv
module vpci_regs import vpci_pkg::*; #(
  parameter int NQ      = 8,
  parameter int MAX_VEC = 31,
  parameter int AW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          msix_en,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [1:0]    bus_size,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [31:0]   host_feat_i,
  input  logic [15:0]   sel_qsize_i,
  output logic [15:0]   qsel_o,
  input  logic [1:0]    isr_set_i,
  output logic          irq_o,
  output logic          notify_o,
  output logic [15:0]   notify_idx_o,
  output logic          dev_reset_o,
  output logic          cfg_req_o,
  output logic          cfg_we_o,
  output logic [1:0]    cfg_size_o,
  output logic [AW-1:0] cfg_addr_o,
  output logic [31:0]   cfg_wdata_o,
  input  logic [31:0]   cfg_rdata_i
);
  localparam int QW = $clog2(NQ);

  reg_e          reg_id;
  logic          in_dev;
  logic [AW-1:0] dev_off;

  logic [31:0] gfeat_q;
  logic [7:0]  status_q;
  logic [7:0]  isr_q;
  logic [15:0] cvec_q;
  logic [BASE_W-1:0] base_rd;
  logic [15:0]       qvec_rd;

  // named internal events
  logic hdr_wr, hdr_rd;
  logic wr_gfeat, wr_pfn, wr_qsel, wr_notify, wr_status, wr_cvec, wr_qvec;
  logic isr_rd, do_reset, pfn_store, qsel_ok;

  vpci_decode #(.AW(AW)) u_dec (
    .addr(bus_addr), .msix_en(msix_en),
    .reg_id(reg_id), .in_dev(in_dev), .dev_off(dev_off)
  );

  assign hdr_wr    = bus_req &  bus_we & ~in_dev;
  assign hdr_rd    = bus_req & ~bus_we & ~in_dev;
  assign wr_gfeat  = hdr_wr & (reg_id == REG_GFEAT);
  assign wr_pfn    = hdr_wr & (reg_id == REG_PFN);
  assign wr_qsel   = hdr_wr & (reg_id == REG_QSEL);
  assign wr_notify = hdr_wr & (reg_id == REG_NOTIFY);
  assign wr_status = hdr_wr & (reg_id == REG_STATUS);
  assign wr_cvec   = hdr_wr & (reg_id == REG_CVEC);
  assign wr_qvec   = hdr_wr & (reg_id == REG_QVEC);
  assign isr_rd    = hdr_rd & (reg_id == REG_ISR);
  assign pfn_store = wr_pfn & (bus_wdata != 32'h0);
  assign do_reset  = (wr_pfn & (bus_wdata == 32'h0)) |
                     (wr_status & (bus_wdata[7:0] == 8'h0));
  assign qsel_ok   = (bus_wdata[15:0] < 16'(NQ));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gfeat_q      <= '0;
      status_q     <= '0;
      isr_q        <= '0;
      qsel_o       <= '0;
      cvec_q       <= NO_VECTOR;
      notify_o     <= 1'b0;
      notify_idx_o <= '0;
      dev_reset_o  <= 1'b0;
    end else begin
      notify_o    <= wr_notify;
      dev_reset_o <= do_reset;
      if (wr_notify) notify_idx_o <= bus_wdata[15:0];
      isr_q <= ((isr_rd | do_reset) ? 8'h0 : isr_q) | {6'b0, isr_set_i};
      if (do_reset) begin
        gfeat_q  <= '0;
        status_q <= '0;
        qsel_o   <= '0;
        cvec_q   <= NO_VECTOR;
      end else begin
        if (wr_gfeat)            gfeat_q  <= guest_accept(bus_wdata);
        if (wr_status)           status_q <= bus_wdata[7:0];
        if (wr_qsel && qsel_ok)  qsel_o   <= bus_wdata[15:0];
        if (wr_cvec)             cvec_q   <= vec_clamp(bus_wdata[15:0], MAX_VEC);
      end
    end
  end

  vpci_qtable #(.NQ(NQ)) u_qtab (
    .clk(clk), .rst_n(rst_n), .clr(do_reset),
    .sel(qsel_o[QW-1:0]),
    .base_we(pfn_store), .base_wd(pfn_to_base(bus_wdata)),
    .vec_we(wr_qvec), .vec_wd(vec_clamp(bus_wdata[15:0], MAX_VEC)),
    .base_rd(base_rd), .vec_rd(qvec_rd)
  );

  always_comb begin
    bus_rdata = 32'hFFFF_FFFF;
    if (in_dev) bus_rdata = cfg_rdata_i;
    else begin
      case (reg_id)
        REG_HFEAT:  bus_rdata = host_view(host_feat_i);
        REG_GFEAT:  bus_rdata = gfeat_q;
        REG_PFN:    bus_rdata = base_to_pfn(base_rd);
        REG_QNUM:   bus_rdata = {16'h0, sel_qsize_i};
        REG_QSEL:   bus_rdata = {16'h0, qsel_o};
        REG_STATUS: bus_rdata = {24'h0, status_q};
        REG_ISR:    bus_rdata = {24'h0, isr_q};
        REG_CVEC:   bus_rdata = {16'h0, cvec_q};
        REG_QVEC:   bus_rdata = {16'h0, qvec_rd};
        default:    bus_rdata = 32'hFFFF_FFFF;
      endcase
    end
  end

  assign irq_o       = ~msix_en & isr_q[0];
  assign cfg_req_o   = bus_req & in_dev;
  assign cfg_we_o    = bus_we;
  assign cfg_size_o  = bus_size;
  assign cfg_addr_o  = dev_off;
  assign cfg_wdata_o = bus_wdata;
endmodule

// File: rtl/vpci_regs_chk.sv
module vpci_regs_chk #(
  parameter int NQ = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        msix_en,
  input logic [31:0] bus_wdata,
  input logic [1:0]  isr_set_i,
  input logic        irq_o,
  input logic        notify_o,
  input logic [15:0] notify_idx_o,
  input logic        dev_reset_o,
  input logic [15:0] qsel_o,
  input logic        wr_notify,
  input logic        wr_gfeat,
  input logic        isr_rd,
  input logic [31:0] gfeat_q,
  input logic [7:0]  isr_q
);
  AST_NOTIFY_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    notify_o |-> $past(wr_notify)); // R8
  AST_NOTIFY_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    wr_notify |=> (notify_idx_o == $past(bus_wdata[15:0]))); // R8
  AST_ISR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_rd && isr_set_i == 2'b00) |=> (isr_q == 8'h0)); // R9
  AST_ISR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_set_i != 2'b00) |=> ((isr_q[1:0] & $past(isr_set_i)) == $past(isr_set_i))); // R9
  AST_QSEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (qsel_o < 16'(NQ))); // R7
  AST_BAD_FEATURE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_gfeat && bus_wdata[30]) |=> (gfeat_q == 32'h0)); // R3
  AST_DEVRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset_o |-> (qsel_o == 16'h0 && gfeat_q == 32'h0)); // R5
  AST_MSIX_IRQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    msix_en |-> !irq_o); // R10
endmodule

bind vpci_regs vpci_regs_chk #(.NQ(NQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .msix_en(msix_en), .bus_wdata(bus_wdata),
  .isr_set_i(isr_set_i), .irq_o(irq_o), .notify_o(notify_o),
  .notify_idx_o(notify_idx_o), .dev_reset_o(dev_reset_o), .qsel_o(qsel_o),
  .wr_notify(wr_notify), .wr_gfeat(wr_gfeat), .isr_rd(isr_rd),
  .gfeat_q(gfeat_q), .isr_q(isr_q)
);

// File: tb/vpci_regs_bench.sv
`timescale 1ns/100ps
module vpci_regs_bench;
  localparam int NQ = 8;
  localparam int MAXV = 31;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic msix_en = 1'b0;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_size = 2'd2;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] host_feat = 32'h0000_1235;
  logic [15:0] sel_qsize, qsel_o;
  logic [1:0] isr_set = 2'b00;
  logic irq_o, notify_o, dev_reset_o;
  logic [15:0] notify_idx_o;
  logic cfg_req_o, cfg_we_o;
  logic [1:0] cfg_size_o;
  logic [AW-1:0] cfg_addr_o;
  logic [31:0] cfg_wdata_o, cfg_rdata;

  always #2.5 clk = ~clk;

  assign sel_qsize = 16'h0100 + qsel_o * 16'd2;
  assign cfg_rdata = {16'hCF60, 8'h00, cfg_addr_o};

  vpci_regs #(.NQ(NQ), .MAX_VEC(MAXV), .AW(AW)) u_vpci_regs (
    .clk(clk), .rst_n(rst_n), .msix_en(msix_en),
    .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .host_feat_i(host_feat), .sel_qsize_i(sel_qsize), .qsel_o(qsel_o),
    .isr_set_i(isr_set), .irq_o(irq_o), .notify_o(notify_o),
    .notify_idx_o(notify_idx_o), .dev_reset_o(dev_reset_o),
    .cfg_req_o(cfg_req_o), .cfg_we_o(cfg_we_o), .cfg_size_o(cfg_size_o),
    .cfg_addr_o(cfg_addr_o), .cfg_wdata_o(cfg_wdata_o), .cfg_rdata_i(cfg_rdata)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_gfeat, m_pfn [NQ];
  logic [15:0] m_vec [NQ];
  logic [15:0] m_cvec, m_qsel;
  logic [7:0]  m_status, m_isr;
  bit m_msix = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic m_clear();
    m_gfeat = 0; m_status = 0; m_isr = 0; m_qsel = 0; m_cvec = 16'hFFFF;
    for (int q = 0; q < NQ; q++) begin m_pfn[q] = 0; m_vec[q] = 16'hFFFF; end
  endtask

  function automatic logic [31:0] f_host(input logic [31:0] f);
    return f | 32'h5100_0000;
  endfunction
  function automatic logic [31:0] f_guest(input logic [31:0] v);
    return (v & 32'h4000_0000) != 0 ? 32'h0 : v;
  endfunction
  function automatic logic [15:0] f_vec(input logic [15:0] v);
    return (v > 16'(MAXV)) ? 16'hFFFF : v;
  endfunction
  function automatic int hdr_now();
    return m_msix ? 24 : 20;
  endfunction

  function automatic logic [31:0] exp_read(input int a);
    int h;
    h = hdr_now();
    if (a >= h) return {16'hCF60, 8'h00, 8'(a - h)};
    case (a)
      0:  return f_host(host_feat);
      4:  return m_gfeat;
      8:  return m_pfn[m_qsel];
      12: return {16'h0, 16'h0100 + m_qsel * 16'd2};
      14: return {16'h0, m_qsel};
      18: return {24'h0, m_status};
      19: return {24'h0, m_isr};
      20: return {16'h0, m_cvec};
      22: return {16'h0, m_vec[m_qsel]};
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic string rtag(input int a);
    if (a >= hdr_now()) return "R12";
    case (a)
      0: return "R2";
      4: return "R3";
      8: return "R4";
      12, 14: return "R7";
      18: return "R6";
      19: return "R9";
      20, 22: return "R11";
      default: return "R13";
    endcase
  endfunction

  task automatic access(input bit we, input int a, input logic [31:0] wd,
                        input logic [1:0] set, output logic [31:0] rd);
    logic [31:0] exp_rd;
    bit rst_e, ntf_e, isr_clr;
    int h;
    @(negedge clk);
    h = hdr_now();
    exp_rd = exp_read(a);
    bus_req = 1; bus_we = we; bus_addr = AW'(a); bus_wdata = wd; isr_set = set;
    #1;
    rd = bus_rdata;
    if (!we) chk(rd == exp_rd, rtag(a), rd, exp_rd);
    chk(cfg_req_o == (a >= h), "R12", 32'(cfg_req_o), 32'(a >= h));
    if (a >= h) chk(cfg_addr_o == AW'(a - h), "R12", 32'(cfg_addr_o), 32'(a - h));
    rst_e = 0; ntf_e = 0; isr_clr = 0;
    if (a < h) begin
      if (we) begin
        case (a)
          4:  m_gfeat = f_guest(wd);
          8:  if (wd == 0) rst_e = 1; else m_pfn[m_qsel] = wd;
          14: if (wd[15:0] < 16'(NQ)) m_qsel = wd[15:0];
          16: ntf_e = 1;
          18: begin m_status = wd[7:0]; if (wd[7:0] == 0) rst_e = 1; end
          20: m_cvec = f_vec(wd[15:0]);
          22: m_vec[m_qsel] = f_vec(wd[15:0]);
          default: ;
        endcase
      end else if (a == 19) isr_clr = 1;
    end
    if (rst_e) begin
      m_gfeat = 0; m_status = 0; m_qsel = 0; m_cvec = 16'hFFFF;
      for (int q = 0; q < NQ; q++) begin m_pfn[q] = 0; m_vec[q] = 16'hFFFF; end
    end
    m_isr = ((rst_e || isr_clr) ? 8'h0 : m_isr) | {6'b0, set};
    @(negedge clk);
    bus_req = 0; bus_we = 0; isr_set = 2'b00;
    #1;
    chk(dev_reset_o == rst_e, rst_e ? "R5" : "R6", 32'(dev_reset_o), 32'(rst_e));
    chk(notify_o == ntf_e, "R8", 32'(notify_o), 32'(ntf_e));
    if (ntf_e) chk(notify_idx_o == wd[15:0], "R8", 32'(notify_idx_o), 32'(wd[15:0]));
    chk(irq_o == (!m_msix && m_isr[0]), "R10", 32'(irq_o), 32'(!m_msix && m_isr[0]));
  endtask

  task automatic set_msix(input bit b);
    @(negedge clk);
    msix_en = b; m_msix = b;
  endtask

  task automatic rd_chk(input int a, input string tag, input logic [31:0] exp);
    logic [31:0] r;
    access(0, a, 0, 2'b00, r);
    chk(r == exp, tag, r, exp);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    logic [31:0] r;
    access(1, a, d, 2'b00, r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd4242));
    m_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk(irq_o == 0, "R1", 32'(irq_o), 0);
    rd_chk(4, "R1", 0); rd_chk(18, "R1", 0); rd_chk(19, "R1", 0);
    rd_chk(14, "R1", 0); rd_chk(8, "R1", 0);
    set_msix(1);
    rd_chk(20, "R1", 32'hFFFF); rd_chk(22, "R1", 32'hFFFF);
    // R2
    rd_chk(0, "R2", 32'h5100_1235);
    // R3
    wr(4, 32'h0000_00F3); rd_chk(4, "R3", 32'h0000_00F3);
    wr(4, 32'h4000_0001); rd_chk(4, "R3", 0);
    // R4, R11: two queues
    wr(14, 3); wr(8, 32'hABCDE); wr(22, 7); wr(20, 40);
    wr(14, 5); wr(8, 32'h12345); wr(22, 50);
    rd_chk(8, "R4", 32'h12345); rd_chk(22, "R11", 32'hFFFF); rd_chk(20, "R11", 32'hFFFF);
    wr(14, 3); rd_chk(8, "R4", 32'hABCDE); rd_chk(22, "R11", 7);
    // R7: out of range select ignored
    wr(14, NQ); rd_chk(14, "R7", 3); rd_chk(12, "R7", 32'h0106);
    // R13: undecoded offset
    rd_chk(1, "R13", 32'hFFFF_FFFF); rd_chk(16, "R13", 32'hFFFF_FFFF);
    wr(13, 32'h7); rd_chk(12, "R13", 32'h0106); rd_chk(14, "R13", 3);
    // R5, R14: zero page frame resets
    wr(18, 32'h1FF); rd_chk(18, "R6", 32'hFF);
    wr(8, 0);
    rd_chk(8, "R14", 0); rd_chk(22, "R14", 32'hFFFF); rd_chk(20, "R14", 32'hFFFF);
    rd_chk(14, "R5", 0); rd_chk(18, "R5", 0);
    // R8
    wr(16, 32'hBEEF_0006);
    // R12: device region with each mode
    rd_chk(24, "R12", 32'hCF60_0000); rd_chk(30, "R12", 32'hCF60_0006);
    set_msix(0);
    rd_chk(20, "R12", 32'hCF60_0000); rd_chk(22, "R12", 32'hCF60_0002);
    // R9/R10: interrupt status
    access(0, 4, 0, 2'b01, r);
    chk(irq_o == 1, "R10", 32'(irq_o), 1);
    access(0, 19, 0, 2'b00, r);
    chk(r == 1, "R9", r, 1);
    chk(irq_o == 0, "R9", 32'(irq_o), 0);
    access(0, 4, 0, 2'b11, r);
    access(0, 19, 0, 2'b10, r);  // set collides with clearing read
    chk(r == 3, "R9", r, 3);
    rd_chk(19, "R9", 2);
    access(0, 4, 0, 2'b01, r);
    set_msix(1);
    #1 chk(irq_o == 0, "R10", 32'(irq_o), 0);
    set_msix(0);
    #1 chk(irq_o == 1, "R10", 32'(irq_o), 1);
    // R6: status zero reset
    wr(18, 32'h0000_0300);
    rd_chk(18, "R6", 0);
    rd_chk(19, "R6", 0);
    // random phase
    for (int i = 0; i < 600; i++) begin
      int a, k;
      bit we;
      logic [31:0] d;
      logic [1:0] s;
      if ($urandom_range(0, 19) == 0) set_msix(bit'($urandom_range(0, 1)));
      k = $urandom_range(0, 15);
      case (k)
        0: a = 0; 1: a = 4; 2: a = 8; 3: a = 12; 4: a = 14; 5: a = 16;
        6: a = 18; 7, 8: a = 19; 9: a = 20; 10: a = 22;
        default: a = $urandom_range(0, 31);
      endcase
      we = bit'($urandom_range(0, 1));
      d = $urandom();
      if (a == 14) d = 32'($urandom_range(0, NQ + 2));
      if ((a == 20 || a == 22) && $urandom_range(0, 1) == 1) d = 32'($urandom_range(0, MAXV));
      if ((a == 8 || a == 18) && $urandom_range(0, 7) == 0) d = 0;
      if ((a == 18) && $urandom_range(0, 1) == 1) d = d | 32'h1;
      s = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      access(we, a, d, s, r);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule